// File: doc/BRIEF.md
# Morse Digit Encoder with Playback Queue

This block turns decimal digits into timed on/off keying on one output line. Each digit becomes five elements. An element is a short mark (dot) or a long mark (dash), and a fixed-length low space separates neighbouring elements. A busy flag shows when the line is being driven with a digit or with the pause between two digits.

There are two modes. With the mode select low, one start pulse sends the digit presented on the 4-bit digit input. With the mode select high, a start pulse instead appends the digit to a six-entry first-in first-out queue. A separate encode pulse then plays back every queued digit, oldest first, with a longer pause between digits.

All durations are whole multiples of one time unit, set by the `HALF_SEC_CYCLES` parameter. Its default of 50,000,000 is half a second at 100 MHz. All control pulses are single-cycle and already debounced.

Top module: `morse_digit_encoder`

## Requirements
- R1: With U = `HALF_SEC_CYCLES`, a dot holds `morse_out` high for 2U cycles and a dash for 6U cycles. A space between elements is low for U cycles. The pause between queued digits is low for 4U cycles. The first mark starts in the cycle after the accepting clock edge.
- R2: Every digit is sent as exactly five elements, taken from a 5-bit code with the most significant bit first, where 1 is a dot and 0 is a dash. The codes are 0=00000, 1=10000, 2=11000, 3=11100, 4=11110, 5=11111, 6=01111, 7=00111, 8=00011, 9=00001.
- R3: With `number_mode` = 0 and the block idle, a `start_pulse` sends `digit_in` once. The block then returns to idle.
- R4: With `number_mode` = 1, a `start_pulse` while idle stores `digit_in` and does not start sending. An `encode_pulse` while idle with a non-empty queue sends all queued digits in the order they were stored, with the 4U pause between consecutive digits. No space follows the fifth element of a digit. After the last digit the block goes straight to idle with the queue empty.
- R5: The queue holds six digits. A store attempted while six digits are held is dropped.
- R6: Digit values 10 to 15 are neither sent nor stored, in either mode.
- R7: A start or encode pulse that arrives while `busy` is high has no effect. An encode pulse with an empty queue has no effect.
- R8: `busy` is high from the first cycle of the first mark until the last mark ends, including spaces and inter-digit pauses. It is low when idle.
- R9: A synchronous reset (`rst` high at a clock edge) drives `morse_out` and `busy` low, abandons any transmission and empties the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| number_mode | input | 1 | 0: send-immediately mode, 1: queue mode |
| digit_in | input | 4 | Digit to send or store |
| start_pulse | input | 1 | Send (mode 0) or store (mode 1) request, one cycle |
| encode_pulse | input | 1 | Play back the queue (mode 1), one cycle |
| morse_out | output | 1 | Keyed Morse line, high during marks |
| busy | output | 1 | High while a digit or an inter-digit pause is in progress |

## Verification
The bench builds the block with `HALF_SEC_CYCLES` set to 2. A dot then lasts 4 cycles, a dash 12, a space 2 and a pause 8, so every digit and a full six-digit playback can be compared cycle by cycle against the expected keying. The queue depth stays at its default of six, so the full-queue drop, FIFO ordering and reset emptying are all exercised at the real depth.

// File: rtl/morse_pkg.sv
package morse_pkg;

   localparam int unsigned DIGIT_W = 4;
   localparam int unsigned ELEM_N  = 5;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_t;

   // Decimal digits only.
   function automatic logic digit_ok(input logic [DIGIT_W-1:0] d);
      return d <= DIGIT_W'(9);
   endfunction

   // Dot = 1, dash = 0, first element in bit ELEM_N-1.
   // 0..5: d leading dots, then dashes.  6..9: d-5 leading dashes, then dots.
   function automatic logic [ELEM_N-1:0] digit_code(input logic [DIGIT_W-1:0] d);
      logic [ELEM_N-1:0] ones;
      ones = '1;
      if (d <= DIGIT_W'(5))
         return ~(ones >> d);
      else
         return ones >> (d - DIGIT_W'(5));
   endfunction

endpackage

// File: rtl/morse_digit_queue.sv
module morse_digit_queue #(
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic              full
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_q, rd_q, wr_nx, rd_nx;
   logic [CNT_W-1:0]  cnt_q;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2_wrap
         assign wr_nx = wr_q + 1'b1;
         assign rd_nx = rd_q + 1'b1;
      end else begin : g_cmp_wrap
         assign wr_nx = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nx = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_nx;
         if (pop)  rd_q <= rd_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem_q[rd_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));

   // R5: the controller never writes into a full queue
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      push |-> !full);

   // R4: the controller never takes from an empty queue
   assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

endmodule

// File: rtl/morse_down_timer.sv
module morse_down_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/morse_sequencer.sv
module morse_sequencer
   import morse_pkg::*;
#(
   parameter int unsigned UNIT_CYCLES = 50_000_000
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               number_mode,
   input  logic [DIGIT_W-1:0] digit_in,
   input  logic               start_pulse,
   input  logic               encode_pulse,
   input  logic               q_empty,
   input  logic               q_full,
   input  logic [DIGIT_W-1:0] q_head,
   output logic               q_push,
   output logic               q_pop,
   output logic               morse_out,
   output logic               busy
);

   localparam int unsigned DOT_C   = 2 * UNIT_CYCLES;
   localparam int unsigned DASH_C  = 6 * UNIT_CYCLES;
   localparam int unsigned SPACE_C = UNIT_CYCLES;
   localparam int unsigned GAP_C   = 4 * UNIT_CYCLES;
   localparam int unsigned CNT_W   = $clog2(DASH_C + 1);
   localparam int unsigned EIDX_W  = $clog2(ELEM_N);

   seq_state_t          state_q, state_d;
   logic                mark_q, mark_d;
   logic [EIDX_W-1:0]   elem_q, elem_d;
   logic [ELEM_N-1:0]   code_q, code_d, new_code;
   logic                fromq_q, fromq_d;
   logic                t_load, t_done;
   logic [CNT_W-1:0]    t_val;
   logic                idle, go_single, go_queue, gap_done;

   function automatic logic [CNT_W-1:0] mark_load(input logic is_dot);
      return is_dot ? CNT_W'(DOT_C - 1) : CNT_W'(DASH_C - 1);
   endfunction

   morse_down_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_done)
   );

   assign idle      = (state_q == ST_IDLE);
   assign go_single = idle && !number_mode && start_pulse && digit_ok(digit_in);
   assign go_queue  = idle && number_mode && encode_pulse && !q_empty;
   assign q_push    = idle && number_mode && start_pulse && !encode_pulse
                      && digit_ok(digit_in) && !q_full;
   assign gap_done  = (state_q == ST_GAP) && t_done;
   assign q_pop     = go_queue || gap_done;
   assign new_code  = digit_code(go_single ? digit_in : q_head);

   always_comb begin
      state_d = state_q;
      mark_d  = mark_q;
      elem_d  = elem_q;
      code_d  = code_q;
      fromq_d = fromq_q;
      t_load  = 1'b0;
      t_val   = '0;
      case (state_q)
         ST_IDLE: begin
            if (go_single || go_queue) begin
               state_d = ST_SEND;
               mark_d  = 1'b1;
               elem_d  = '0;
               code_d  = new_code;
               fromq_d = go_queue;
               t_load  = 1'b1;
               t_val   = mark_load(new_code[ELEM_N-1]);
            end
         end
         ST_SEND: begin
            if (t_done) begin
               if (mark_q) begin
                  if (elem_q == EIDX_W'(ELEM_N - 1)) begin
                     if (fromq_q && !q_empty) begin
                        state_d = ST_GAP;
                        t_load  = 1'b1;
                        t_val   = CNT_W'(GAP_C - 1);
                     end else begin
                        state_d = ST_IDLE;
                     end
                  end else begin
                     mark_d = 1'b0;
                     t_load = 1'b1;
                     t_val  = CNT_W'(SPACE_C - 1);
                  end
               end else begin
                  mark_d = 1'b1;
                  elem_d = elem_q + 1'b1;
                  code_d = {code_q[ELEM_N-2:0], 1'b0};
                  t_load = 1'b1;
                  t_val  = mark_load(code_q[ELEM_N-2]);
               end
            end
         end
         ST_GAP: begin
            if (t_done) begin
               state_d = ST_SEND;
               mark_d  = 1'b1;
               elem_d  = '0;
               code_d  = new_code;
               t_load  = 1'b1;
               t_val   = mark_load(new_code[ELEM_N-1]);
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         mark_q  <= 1'b0;
         elem_q  <= '0;
         code_q  <= '0;
         fromq_q <= 1'b0;
      end else begin
         state_q <= state_d;
         mark_q  <= mark_d;
         elem_q  <= elem_d;
         code_q  <= code_d;
         fromq_q <= fromq_d;
      end
   end

   assign morse_out = (state_q == ST_SEND) && mark_q;
   assign busy      = !idle;

   // Run-length observers used only by the properties below.
   int unsigned hi_run_q, lo_run_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         hi_run_q <= 0;
         lo_run_q <= 0;
      end else begin
         hi_run_q <= morse_out ? hi_run_q + 1 : 0;
         lo_run_q <= (!morse_out && busy) ? lo_run_q + 1 : 0;
      end
   end

   // R1: every completed mark is a dot or a dash length
   assert_mark_len_R1: assert property (@(posedge clk) disable iff (rst)
      ($fell(morse_out) && !$past(rst)) |-> (hi_run_q == DOT_C || hi_run_q == DASH_C));

   // R1: every low stretch inside a transmission is a space or a pause
   assert_space_len_R1: assert property (@(posedge clk) disable iff (rst)
      ($rose(morse_out) && $past(busy)) |-> (lo_run_q == SPACE_C || lo_run_q == GAP_C));

   // R8: a transmission opens with a mark
   assert_first_mark_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> morse_out);

   // R4: no trailing space or pause before idle
   assert_end_on_mark_R4: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> $past(morse_out));

endmodule

// File: rtl/morse_digit_encoder.sv
module morse_digit_encoder
   import morse_pkg::*;
#(
   parameter int unsigned HALF_SEC_CYCLES = 50_000_000,
   parameter int unsigned QUEUE_DEPTH     = 6
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       number_mode,
   input  logic [3:0] digit_in,
   input  logic       start_pulse,
   input  logic       encode_pulse,
   output logic       morse_out,
   output logic       busy
);

   generate
      if (HALF_SEC_CYCLES < 1) begin : g_bad_unit
         $error("HALF_SEC_CYCLES must be at least 1");
      end
      if (QUEUE_DEPTH < 2) begin : g_bad_depth
         $error("QUEUE_DEPTH must be at least 2");
      end
      if (DIGIT_W != 4) begin : g_bad_width
         $error("digit width must be 4");
      end
   endgenerate

   logic               q_push, q_pop, q_empty, q_full;
   logic [DIGIT_W-1:0] q_head;

   morse_digit_queue #(
      .DEPTH  (QUEUE_DEPTH),
      .DATA_W (DIGIT_W)
   ) u_queue (
      .clk       (clk),
      .rst       (rst),
      .push      (q_push),
      .push_data (digit_in),
      .pop       (q_pop),
      .head      (q_head),
      .empty     (q_empty),
      .full      (q_full)
   );

   morse_sequencer #(
      .UNIT_CYCLES (HALF_SEC_CYCLES)
   ) u_seq (
      .clk          (clk),
      .rst          (rst),
      .number_mode  (number_mode),
      .digit_in     (digit_in),
      .start_pulse  (start_pulse),
      .encode_pulse (encode_pulse),
      .q_empty      (q_empty),
      .q_full       (q_full),
      .q_head       (q_head),
      .q_push       (q_push),
      .q_pop        (q_pop),
      .morse_out    (morse_out),
      .busy         (busy)
   );

endmodule

// File: tb/morse_digit_encoder_test.sv
`timescale 1ns/1ps
module morse_digit_encoder_test;

   localparam int U = 2;

   // Code table per R2: 1 = dot, 0 = dash, MSB sent first.
   localparam logic [4:0] CODE [10] = '{
      5'b00000, 5'b10000, 5'b11000, 5'b11100, 5'b11110,
      5'b11111, 5'b01111, 5'b00111, 5'b00011, 5'b00001
   };

   // Vector = {digit, accepted}
   localparam logic [4:0] VEC [12] = '{
      {4'd0, 1'b1}, {4'd1, 1'b1}, {4'd2, 1'b1}, {4'd3, 1'b1},
      {4'd4, 1'b1}, {4'd5, 1'b1}, {4'd6, 1'b1}, {4'd7, 1'b1},
      {4'd8, 1'b1}, {4'd9, 1'b1}, {4'd10, 1'b0}, {4'd15, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       number_mode = 1'b0;
   logic [3:0] digit_in = 4'd0;
   logic       start_pulse = 1'b0;
   logic       encode_pulse = 1'b0;
   logic       morse_out, busy;

   int errs = 0;
   int checks = 0;
   int cyc = 0;
   logic       inj_en = 1'b0;
   int         inj_at = 0;
   logic [3:0] inj_digit = 4'd0;

   always #2.5 clk = ~clk;

   morse_digit_encoder #(.HALF_SEC_CYCLES(U), .QUEUE_DEPTH(6)) uut (
      .clk          (clk),
      .rst          (rst),
      .number_mode  (number_mode),
      .digit_in     (digit_in),
      .start_pulse  (start_pulse),
      .encode_pulse (encode_pulse),
      .morse_out    (morse_out),
      .busy         (busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp_v,
                      input string what);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp_v, $time);
      end
   endtask

   task automatic step();
      if (inj_en && cyc == inj_at) begin
         start_pulse  = 1'b1;
         encode_pulse = 1'b1;
         digit_in     = inj_digit;
      end else begin
         start_pulse  = 1'b0;
         encode_pulse = 1'b0;
      end
      cyc++;
      @(negedge clk);
   endtask

   task automatic expect_span(input bit lvl, input int n, input string req);
      for (int c = 0; c < n; c++) begin
         chk(morse_out == lvl, req, morse_out, lvl, "morse_out");
         chk(busy == 1'b1, "R8", busy, 1, "busy during transmission");
         step();
      end
   endtask

   task automatic expect_digit(input logic [3:0] d);
      logic [4:0] p;
      p = CODE[d];
      for (int i = 0; i < 5; i++) begin
         expect_span(1'b1, p[4-i] ? 2*U : 6*U, "R2");
         if (i < 4) expect_span(1'b0, U, "R1");
      end
   endtask

   task automatic play(input int n, input logic [3:0] ds [6], input string endreq);
      cyc = 0;
      for (int k = 0; k < n; k++) begin
         expect_digit(ds[k]);
         if (k < n - 1) expect_span(1'b0, 4*U, "R4");
      end
      start_pulse  = 1'b0;
      encode_pulse = 1'b0;
      chk(busy == 1'b0, endreq, busy, 0, "busy after last mark");
      chk(morse_out == 1'b0, endreq, morse_out, 0, "morse_out after last mark");
   endtask

   task automatic kick_start(input logic m, input logic [3:0] d);
      number_mode = m;
      digit_in    = d;
      start_pulse = 1'b1;
      @(negedge clk);
      start_pulse = 1'b0;
   endtask

   task automatic kick_encode();
      number_mode  = 1'b1;
      encode_pulse = 1'b1;
      @(negedge clk);
      encode_pulse = 1'b0;
   endtask

   task automatic store(input logic [3:0] d);
      kick_start(1'b1, d);
      chk(busy == 1'b0, "R4", busy, 0, "store does not send");
   endtask

   task automatic expect_quiet(input int n, input string req, input string what);
      for (int c = 0; c < n; c++) begin
         chk(busy == 1'b0 && morse_out == 1'b0, req, busy, 0, what);
         @(negedge clk);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [3:0] dl [6];
      foreach (dl[i]) dl[i] = 4'd0;

      // R9: reset state
      repeat (3) @(negedge clk);
      chk(morse_out == 1'b0, "R9", morse_out, 0, "morse_out in reset");
      chk(busy == 1'b0, "R9", busy, 0, "busy in reset");
      rst = 1'b0;
      @(negedge clk);

      // Vector walk: single-digit mode (R3, R6)
      for (int i = 0; i < 12; i++) begin
         kick_start(1'b0, VEC[i][4:1]);
         if (VEC[i][0]) begin
            dl[0] = VEC[i][4:1];
            play(1, dl, "R3");
            expect_quiet(3, "R3", "idle after single digit");
         end else begin
            expect_quiet(6, "R6", "invalid digit not sent");
         end
      end

      // R4 + R6: store 3, invalid 11, 5; play back in order
      store(4'd3);
      store(4'd11);
      store(4'd5);
      kick_encode();
      dl[0] = 4'd3; dl[1] = 4'd5;
      play(2, dl, "R4");
      kick_encode();
      expect_quiet(4, "R4", "queue empty after playback");

      // R5: seven stores, only six kept
      for (int d = 1; d <= 7; d++) store(4'(d));
      kick_encode();
      for (int k = 0; k < 6; k++) dl[k] = 4'(k + 1);
      play(6, dl, "R5");
      kick_encode();
      expect_quiet(4, "R5", "seventh store dropped");

      // R7: pulses during single-digit send ignored
      inj_en = 1'b1; inj_at = 3; inj_digit = 4'd2;
      kick_start(1'b0, 4'd5);
      dl[0] = 4'd5;
      play(1, dl, "R7");
      inj_en = 1'b0;
      expect_quiet(3, "R7", "no extra digit after ignored start");

      // R7: store/encode during queue playback ignored
      store(4'd8);
      inj_en = 1'b1; inj_at = 5; inj_digit = 4'd1;
      kick_encode();
      dl[0] = 4'd8;
      play(1, dl, "R7");
      inj_en = 1'b0;
      kick_encode();
      expect_quiet(4, "R7", "store during playback ignored");

      // R7: encode on empty queue
      kick_encode();
      expect_quiet(3, "R7", "encode with empty queue");

      // R9: reset mid-transmission empties the queue
      store(4'd2);
      store(4'd9);
      kick_encode();
      repeat (3) @(negedge clk);
      chk(morse_out == 1'b1, "R9", morse_out, 1, "mark before reset");
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(morse_out == 1'b0, "R9", morse_out, 0, "morse_out after reset");
      chk(busy == 1'b0, "R9", busy, 0, "busy after reset");
      kick_encode();
      expect_quiet(4, "R9", "queue emptied by reset");

      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule